// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Scheduler

This block owns the refresh timing of an asynchronous DRAM. After reset it holds the strobes idle for a power-up pause. It then runs a fixed burst of refresh cycles on its own. When the burst ends it raises a done flag, and the access sequencer uses that flag to gate its own readiness.

Once initialized, an interval timer marks each refresh slot. A counter keeps track of the refreshes that are owed. While anything is owed, the block raises a request to the access sequencer. It takes the RAS/CAS/WE strobes only after the sequencer grants them, so an access in progress is never cut short. A late grant does not lose refreshes: every slot that passes adds to the count, and the owed refreshes then run back to back. An error flag latches if the debt ever grows past a set limit.

Each refresh is CAS-before-RAS by default: CAS leads RAS, RAS holds low, and a precharge follows, with WE held high the whole time. A parameter selects RAS-only refresh instead. In that mode CAS stays high and an internal row counter drives the address lines. All durations are counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, ras_n_o, cas_n_o and we_n_o are 1; own_o, req_o, init_done_o and err_o are 0; owed_o is 0.
- R2: The first strobe activity comes in cycle PAUSE_CYC+1 after reset is released, counting the first rising edge with reset released as cycle 1. In CBR mode this activity is CAS falling; in RAS-only mode it is the row setup state, and RAS falls SETUP_CYC cycles later.
- R3: The init burst is exactly INIT_CNT refreshes, spaced SETUP_CYC+RAS_LOW_CYC+PRECH_CYC+1 cycles apart. It needs no grant and raises no request. init_done_o rises in cycle PAUSE_CYC+INIT_CNT*(SETUP_CYC+RAS_LOW_CYC+PRECH_CYC+1) and then stays high.
- R4: In CBR mode, CAS is low for exactly SETUP_CYC cycles before RAS falls. CAS stays low until RAS rises and goes high together with it. WE stays high throughout.
- R5: RAS stays low for exactly RAS_LOW_CYC cycles. It stays high for at least PRECH_CYC cycles before every fall.
- R6: After init, the strobes are taken (own_o=1) only in the cycle after one in which req_o and gnt_i are both 1. If req_o=1 and gnt_i=0, own_o is 0 in the next cycle.
- R7: The interval timer starts when init_done_o rises and ticks every INTERVAL_CYC cycles. If the grant is held high, the first periodic RAS fall comes in cycle D+INTERVAL_CYC+2+SETUP_CYC, where D is the init-done cycle.
- R8: owed_o rises by one in each tick cycle (cycles D+m*INTERVAL_CYC). It falls by one PRECH_CYC cycles after the rise of RAS in each periodic refresh. It saturates at 2^DEBT_W-1. A tick and a completion in the same cycle leave it unchanged. A request is made while owed_o is nonzero.
- R9: err_o goes to 1 in the cycle after owed_o first exceeds DEBT_LIMIT. It then stays 1 until reset.
- R10: With ROW_REFRESH=1, cas_n_o stays 1. At the n-th RAS fall since reset (n counted from 0), addr_o equals n modulo 2^ROW_W, and addr_o stays stable while RAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gnt_i | input | 1 | Access sequencer idle, RAS high and precharge met |
| req_o | output | 1 | Refresh wants the strobes |
| own_o | output | 1 | Refresh is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| addr_o | output | ROW_W | Refresh row address |
| init_done_o | output | 1 | Power-up sequence complete |
| owed_o | output | DEBT_W | Refreshes owed |
| err_o | output | 1 | Sticky: debt exceeded DEBT_LIMIT |

## Verification
The assertions assume that gnt_i follows the handshake. The sequencer asserts it only when it has RAS high, its precharge is done, and it will stay off the strobes while own_o is high. They also assume that all phase lengths are at least one cycle. The stimulus keeps within these limits in three ways. It changes gnt_i just after a clock edge. It holds the grant high through whole periods, then drops it for long enough to drive the debt into saturation, then returns it. The RAS-only instance has its grant tied high.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE  = 3'd0,
        ST_IDLE   = 3'd1,
        ST_WAIT   = 3'd2,
        ST_SETUP  = 3'd3,
        ST_ACTIVE = 3'd4,
        ST_PRECH  = 3'd5
    } rfs_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_end;

    assign at_end = (tmr_q.cnt == TW'(INTERVAL_CYC - 1));
    assign tick_o = en_i && at_end;

    always_comb begin
        tmr_d = tmr_q;
        if (en_i) begin
            tmr_d.cnt = at_end ? '0 : tmr_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R7: slots are at least two cycles apart
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/rfs_debt_counter.sv
module rfs_debt_counter #(
    parameter int unsigned DEBT_W     = 4,
    parameter int unsigned DEBT_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic [DEBT_W-1:0] owed_o,
    output logic              owed_nz_o,
    output logic              err_o
);
    localparam logic [DEBT_W-1:0] OWED_MAX = '1;
    localparam logic [DEBT_W-1:0] LIMIT    = DEBT_W'(DEBT_LIMIT);

    typedef struct packed {
        logic [DEBT_W-1:0] owed;
        logic              err;
    } debt_t;

    debt_t debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        unique case ({inc_i, dec_i})
            2'b10: if (debt_q.owed != OWED_MAX) debt_d.owed = debt_q.owed + DEBT_W'(1);
            2'b01: if (debt_q.owed != '0)       debt_d.owed = debt_q.owed - DEBT_W'(1);
            default: ;
        endcase
        if (debt_q.owed > LIMIT) debt_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) debt_q <= '0;
        else        debt_q <= debt_d;
    end

    assign owed_o    = debt_q.owed;
    assign owed_nz_o = (debt_q.owed != '0);
    assign err_o     = debt_q.err;

    // R8: the owed count moves by at most one per cycle
    p_owed_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (debt_q.owed != $past(debt_q.owed)) |->
            ((debt_q.owed == $past(debt_q.owed) + DEBT_W'(1)) ||
             (debt_q.owed == $past(debt_q.owed) - DEBT_W'(1))));

    // R8: a lone tick at the ceiling keeps the count there
    p_owed_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (debt_q.owed == OWED_MAX && inc_i && !dec_i) |=> (debt_q.owed == OWED_MAX));

    // R9: the error flag never clears
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q.err |=> debt_q.err);

    // R9: the error flag rises only after the limit was passed
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(debt_q.err) |-> ($past(debt_q.owed) > LIMIT));

endmodule

// File: rtl/rfs_strobe_seq.sv
module rfs_strobe_seq
    import rfs_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 10000,
    parameter int unsigned INIT_CNT    = 8,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned RAS_LOW_CYC = 7,
    parameter int unsigned PRECH_CYC   = 5,
    parameter int unsigned ROW_W       = 10,
    parameter bit          ROW_REFRESH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt_i,
    input  logic             owed_nz_i,
    output logic             req_o,
    output logic             own_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             init_done_o,
    output logic             done_periodic_o
);
    localparam int unsigned PHASE_MAX = max2(max2(PAUSE_CYC, SETUP_CYC), max2(RAS_LOW_CYC, PRECH_CYC));
    localparam int unsigned CNT_W     = $clog2(PHASE_MAX + 1);
    localparam int unsigned INIT_W    = $clog2(INIT_CNT + 1);
    localparam int unsigned RUN_MAX   = max2(RAS_LOW_CYC, PRECH_CYC) + 1;
    localparam int unsigned RUN_W     = $clog2(RUN_MAX + 1);

    typedef struct packed {
        rfs_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [INIT_W-1:0] init_cnt;
        logic              init_done;
        logic [ROW_W-1:0]  row;
    } seq_t;

    seq_t seq_d, seq_q;
    logic done;

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        unique case (seq_q.state)
            ST_PAUSE: begin
                if (seq_q.cnt == CNT_W'(PAUSE_CYC - 1)) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_IDLE: begin
                if (!seq_q.init_done)  seq_d.state = ST_SETUP;
                else if (owed_nz_i)    seq_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (gnt_i) seq_d.state = ST_SETUP;
            end
            ST_SETUP: begin
                if (seq_q.cnt == CNT_W'(SETUP_CYC - 1)) begin
                    seq_d.state = ST_ACTIVE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_ACTIVE: begin
                if (seq_q.cnt == CNT_W'(RAS_LOW_CYC - 1)) begin
                    seq_d.state = ST_PRECH;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_PRECH: begin
                if (seq_q.cnt == CNT_W'(PRECH_CYC - 1)) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                    seq_d.row   = seq_q.row + ROW_W'(1);
                    done        = 1'b1;
                    if (!seq_q.init_done) begin
                        if (seq_q.init_cnt == INIT_W'(INIT_CNT - 1)) seq_d.init_done = 1'b1;
                        else seq_d.init_cnt = seq_q.init_cnt + INIT_W'(1);
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_PAUSE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign own_o           = (seq_q.state == ST_SETUP) || (seq_q.state == ST_ACTIVE) ||
                             (seq_q.state == ST_PRECH);
    assign req_o           = (seq_q.state == ST_WAIT);
    assign ras_n_o         = (seq_q.state != ST_ACTIVE);
    assign we_n_o          = 1'b1;
    assign addr_o          = seq_q.row;
    assign init_done_o     = seq_q.init_done;
    assign done_periodic_o = done && seq_q.init_done;

    generate
        if (ROW_REFRESH) begin : g_row_only
            assign cas_n_o = 1'b1;
            // R10: row address held while RAS is low
            p_row_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (!ras_n_o && !$fell(ras_n_o)) |-> $stable(addr_o));
        end else begin : g_cbr
            assign cas_n_o = !((seq_q.state == ST_SETUP) || (seq_q.state == ST_ACTIVE));
            // R4: CAS already low the cycle before RAS falls
            p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
            // R4: CAS rises together with RAS
            p_cas_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ras_n_o) |-> cas_n_o);
        end
    endgenerate

    // Run-length counters watched by the R5 properties
    logic [RUN_W-1:0] low_run_q, high_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            high_run_q <= RUN_W'(RUN_MAX);
        end else if (!ras_n_o) begin
            high_run_q <= '0;
            if (low_run_q != RUN_W'(RUN_MAX)) low_run_q <= low_run_q + RUN_W'(1);
        end else begin
            low_run_q <= '0;
            if (high_run_q != RUN_W'(RUN_MAX)) high_run_q <= high_run_q + RUN_W'(1);
        end
    end

    // R5: RAS low pulse has the programmed length
    p_ras_low_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (low_run_q == RUN_W'(RAS_LOW_CYC)));

    // R5: precharge met before every RAS fall
    p_prech_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (high_run_q >= RUN_W'(PRECH_CYC)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned PAUSE_CYC    = 10000,
    parameter int unsigned INIT_CNT     = 8,
    parameter int unsigned SETUP_CYC    = 2,
    parameter int unsigned RAS_LOW_CYC  = 7,
    parameter int unsigned PRECH_CYC    = 5,
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned DEBT_W       = 4,
    parameter int unsigned DEBT_LIMIT   = 8,
    parameter int unsigned ROW_W        = 10,
    parameter bit          ROW_REFRESH  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_i,
    output logic              req_o,
    output logic              own_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic              init_done_o,
    output logic [DEBT_W-1:0] owed_o,
    output logic              err_o
);
    logic tick, owed_nz, done_periodic;

    rfs_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (init_done_o),
        .tick_o(tick)
    );

    rfs_debt_counter #(
        .DEBT_W    (DEBT_W),
        .DEBT_LIMIT(DEBT_LIMIT)
    ) u_debt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (tick),
        .dec_i    (done_periodic),
        .owed_o   (owed_o),
        .owed_nz_o(owed_nz),
        .err_o    (err_o)
    );

    rfs_strobe_seq #(
        .PAUSE_CYC  (PAUSE_CYC),
        .INIT_CNT   (INIT_CNT),
        .SETUP_CYC  (SETUP_CYC),
        .RAS_LOW_CYC(RAS_LOW_CYC),
        .PRECH_CYC  (PRECH_CYC),
        .ROW_W      (ROW_W),
        .ROW_REFRESH(ROW_REFRESH)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .gnt_i          (gnt_i),
        .owed_nz_i      (owed_nz),
        .req_o          (req_o),
        .own_o          (own_o),
        .ras_n_o        (ras_n_o),
        .cas_n_o        (cas_n_o),
        .we_n_o         (we_n_o),
        .addr_o         (addr_o),
        .init_done_o    (init_done_o),
        .done_periodic_o(done_periodic)
    );

    // R6: no take while the grant is withheld
    p_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !gnt_i) |=> !own_o);

    // R3: no request before initialization completes
    p_init_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done_o |-> !req_o);

    // R3: init done never drops
    p_init_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);

endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 20;
    localparam int N   = 8;
    localparam int S   = 2;
    localparam int L   = 3;
    localparam int R   = 2;
    localparam int I   = 60;
    localparam int DW  = 3;
    localparam int LIM = 3;
    localparam int RW1 = 3;
    localparam int C   = S + L + R + 1;
    localparam int D   = P + N * C;
    localparam int OMAX = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b1;
    logic gnt1 = 1'b1;

    logic          req0, own0, ras0, cas0, we0, idone0, err0;
    logic [9:0]    addr0;
    logic [DW-1:0] owed0;
    logic          req1, own1, ras1, cas1, we1, idone1, err1;
    logic [RW1-1:0] addr1;
    logic [DW-1:0]  owed1;

    int k = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n) k <= k + 1;

    dram_refresh_sched #(
        .PAUSE_CYC(P), .INIT_CNT(N), .SETUP_CYC(S), .RAS_LOW_CYC(L), .PRECH_CYC(R),
        .INTERVAL_CYC(I), .DEBT_W(DW), .DEBT_LIMIT(LIM), .ROW_W(10), .ROW_REFRESH(1'b0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .gnt_i(gnt), .req_o(req0), .own_o(own0),
        .ras_n_o(ras0), .cas_n_o(cas0), .we_n_o(we0), .addr_o(addr0),
        .init_done_o(idone0), .owed_o(owed0), .err_o(err0)
    );

    dram_refresh_sched #(
        .PAUSE_CYC(P), .INIT_CNT(N), .SETUP_CYC(S), .RAS_LOW_CYC(L), .PRECH_CYC(R),
        .INTERVAL_CYC(I), .DEBT_W(DW), .DEBT_LIMIT(LIM), .ROW_W(RW1), .ROW_REFRESH(1'b1)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .gnt_i(gnt1), .req_o(req1), .own_o(own1),
        .ras_n_o(ras1), .cas_n_o(cas1), .we_n_o(we1), .addr_o(addr1),
        .init_done_o(idone1), .owed_o(owed1), .err_o(err1)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, k);
        end
    endtask

    // Monitor for the CBR instance
    bit p_ras = 1, p_cas = 1, p_idone = 0, p_req = 0, p_gnt = 0;
    int cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 1000;
    int n_init = 0, dec_at = -1, exp_owed = 0, p_exp_owed = 0, max_owed = 0;
    bit exp_err = 0, first_act = 0, first_per = 0, fall_per = 0;

    always @(negedge clk) begin
        if (rst_n && k > 0) begin
            if (!first_act && (!cas0 || !ras0)) begin
                chk(k == P + 1 && !cas0 && ras0, "R2 first CAS fall cycle", k, P + 1);
                first_act = 1;
            end
            if (p_ras && !ras0) begin
                chk(cas_lo_run == S && !cas0, "R4 CAS lead", cas_lo_run, S);
                chk(we0 == 1'b1, "R4 WE high", int'(we0), 1);
                chk(ras_hi_run >= R, "R5 precharge", ras_hi_run, R);
                fall_per = idone0;
                if (!idone0) begin
                    chk(k == P + 1 + S + n_init * C, "R3 init spacing", k, P + 1 + S + n_init * C);
                    n_init++;
                end else if (!first_per) begin
                    chk(k == D + I + 2 + S, "R7 first periodic refresh", k, D + I + 2 + S);
                    first_per = 1;
                end
            end
            if (!p_ras && ras0) begin
                chk(ras_lo_run == L, "R5 RAS low length", ras_lo_run, L);
                chk(cas0 == 1'b1, "R4 CAS release", int'(cas0), 1);
                if (fall_per) dec_at = k + R;
            end
            if (!p_idone && idone0)
                chk(k == D && n_init == N, "R3 init done cycle", k, D);
            if (p_idone && !idone0)
                chk(0, "R3 init done dropped", 0, 1);
            if (req0 && !idone0)
                chk(0, "R3 request during init", 1, 0);
            if (idone0 && p_req)
                chk(own0 == p_gnt, "R6 take follows grant", int'(own0), int'(p_gnt));
            if (k > D) begin
                bit inc, dec;
                inc = ((k - D) % I) == 0;
                dec = (k == dec_at);
                p_exp_owed = exp_owed;
                if (inc && !dec && exp_owed < OMAX) exp_owed++;
                else if (dec && !inc && exp_owed > 0) exp_owed--;
                exp_err = exp_err | (p_exp_owed > LIM);
                chk(int'(owed0) == exp_owed, "R8 owed count", int'(owed0), exp_owed);
                chk(err0 == exp_err, "R9 error flag", int'(err0), int'(exp_err));
                if (int'(owed0) > max_owed) max_owed = int'(owed0);
            end else begin
                chk(owed0 == '0 && !err0, "R8 owed before init", int'(owed0), 0);
            end
            cas_lo_run = cas0 ? 0 : cas_lo_run + 1;
            ras_lo_run = ras0 ? 0 : ras_lo_run + 1;
            ras_hi_run = ras0 ? ras_hi_run + 1 : 0;
            p_ras = ras0; p_cas = cas0; p_idone = idone0; p_req = req0; p_gnt = gnt;
        end
    end

    // Monitor for the RAS-only instance
    bit q_ras = 1, first_act1 = 0;
    int n_row = 0;
    always @(negedge clk) begin
        if (rst_n && k > 0) begin
            if (!cas1) chk(0, "R10 CAS low in row mode", 0, 1);
            if (q_ras && !ras1) begin
                if (!first_act1) begin
                    chk(k == P + 1 + S, "R2 first row-mode RAS fall", k, P + 1 + S);
                    first_act1 = 1;
                end
                chk(int'(addr1) == (n_row % (1 << RW1)), "R10 row address", int'(addr1), n_row % (1 << RW1));
                chk(cas1 == 1'b1, "R10 CAS high at RAS fall", int'(cas1), 1);
                n_row++;
            end
            q_ras = ras1;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(ras0 && cas0 && we0, "R1 strobes idle", {ras0, cas0, we0}, 7);
        chk(!own0 && !req0 && !idone0 && !err0, "R1 flags low", {own0, req0, idone0, err0}, 0);
        chk(owed0 == '0, "R1 owed zero", int'(owed0), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        while (k < 300) @(posedge clk);
        #1 gnt = 1'b0;
        while (k < 900) @(posedge clk);
        #1 gnt = 1'b1;
        while (k < 1200) @(posedge clk);
        @(negedge clk);
        chk(max_owed == OMAX, "R8 saturation reached", max_owed, OMAX);
        chk(owed0 == '0, "R8 debt drained", int'(owed0), 0);
        chk(err0 == 1'b1, "R9 error sticky", int'(err0), 1);
        chk(n_row > (1 << RW1), "R10 row wrap exercised", n_row, (1 << RW1) + 1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d (cycle %0d)", k, 1200, k);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule